// File: doc/BRIEF.md
# PCI Configuration Address Translator

This block sits between a CPU-side configuration window and the PCI host logic. Each CPU access into the window arrives with its window offset, its width and a read or write flag. The block combines the offset with the low half of a mapping register to form a raw 32-bit configuration word. It then turns that word into a type-0 configuration address with the enable bit set. The device number comes from a one-hot select field, found by searching for its lowest set bit. The bus number is taken from a separate input.

Some accesses are refused: requests the mapping register marks as type-1, misaligned accesses, and accesses whose select field is empty. On a refusal nothing is forwarded, and a refused read is given all-ones data of its own width. Each accepted access raises a one-cycle request to clear the received master-abort and target-abort status bits. All results are registered, so they appear one cycle after the strobe.

Top module: `pcicfg_xlate`

## Requirements
- R1: The raw word is {map_reg[15:0], win_off[15:0]}. The forwarded address carries raw bits [10:8] as the function number in cfg_addr[10:8] and raw bits [7:2] as the register number in cfg_addr[7:2], with cfg_addr[1:0] = 0.
- R2: The select field is raw bits [31:11]. The device number in cfg_addr[15:11] is the index, counted from raw bit 11, of the lowest set bit of that field, even when more than one bit is set.
- R3: An accepted access forwards cfg_addr with bit 31 = 1, bits [30:24] = 0 and bits [23:16] = bus_num.
- R4: When map_reg[16] = 1 the access is refused without error. A read gets rej_rdata = 0x000000FF for acc_size 0 (byte), 0x0000FFFF for acc_size 1 (halfword), and 0xFFFFFFFF for acc_size 2 or 3 (word).
- R5: A refused write forwards nothing, does not pulse clr_abort and leaves rej_rdata at 0. An accepted access of either direction also leaves rej_rdata at 0.
- R6: Every accepted access, read or write, drives clr_abort high for exactly the one cycle in which fwd_valid is high. A refused access never drives it.
- R7: A halfword access with win_off[0] = 1, or a word access with win_off[1:0] != 0, is refused with err = 1 when map_reg[16] = 0. A byte access at any offset is aligned.
- R8: An aligned type-0 access with an all-zero select field is refused with err = 1, and a read gets all-ones data as in R4. Later accesses are processed normally.
- R9: Results for a strobe appear exactly one cycle later. In a cycle that follows no strobe, fwd_valid, clr_abort and err are 0 and rej_rdata is 0.
- R10: While rst_n is low, fwd_valid, clr_abort and err are 0, and rej_rdata and cfg_addr are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| win_off | input | 16 | Offset of the access inside the window |
| map_reg | input | 32 | Mapping register: [15:0] upper raw bits, [16] type-1 flag |
| bus_num | input | 8 | Bus number placed in the forwarded address |
| cfg_addr | output | 32 | Translated configuration address, enable bit 31 |
| fwd_valid | output | 1 | cfg_addr is to be forwarded this cycle |
| rej_rdata | output | 32 | All-ones fill for a refused read, else 0 |
| clr_abort | output | 1 | Pulse to clear received-abort status bits |
| err | output | 1 | Misaligned or empty-select access |

## Verification
The bench builds the block with its default parameters: a 16-bit offset, a 32-bit mapping register and an 8-bit bus number. With these values all 21 positions of the select field can be reached, from offset bit 11 up to mapping bit 15. Directed cases place the lowest set bit at each end of the field and on both sides of the boundary between offset and mapping register. They also cover type-1 and misaligned accesses at every width and the empty select field. A seeded random run then mixes these cases with idle cycles.

// File: rtl/pcx_pkg.sv
package pcx_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_WORD3 = 2'd3
  } pcx_size_e;

  localparam int ENABLE_BIT = 31;
endpackage

// File: rtl/pcx_lsb_find.sv
module pcx_lsb_find #(
  parameter int W  = 21,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          none
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end

  assign none = ~|vec;
endmodule

// File: rtl/pcx_screen.sv
module pcx_screen #(
  parameter int DW = 32,
  localparam int NB = DW / 8
) (
  input  logic [1:0]    size,
  input  logic [1:0]    off_lo,
  input  logic          type1,
  input  logic          sel_empty,
  output logic          accept,
  output logic          fault,
  output logic [DW-1:0] fill
);
  import pcx_pkg::*;

  logic misalign;
  logic [NB-1:0] lane_on;

  always_comb begin
    unique case (pcx_size_e'(size))
      SZ_BYTE: misalign = 1'b0;
      SZ_HALF: misalign = off_lo[0];
      default: misalign = |off_lo;
    endcase
  end

  assign fault  = ~type1 & (misalign | sel_empty);
  assign accept = ~type1 & ~misalign & ~sel_empty;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    if (b == 0) begin : g_first
      assign lane_on[b] = 1'b1;
    end else if (b == 1) begin : g_second
      assign lane_on[b] = (size != SZ_BYTE);
    end else begin : g_upper
      assign lane_on[b] = size[1];
    end
    assign fill[b*8 +: 8] = {8{lane_on[b]}};
  end
endmodule

// File: rtl/pcx_pack.sv
module pcx_pack #(
  parameter int BUS_W = 8,
  parameter int DEV_W = 5,
  parameter int DW    = 32
) (
  input  logic [BUS_W-1:0] bus,
  input  logic [DEV_W-1:0] dev,
  input  logic [2:0]       fn,
  input  logic [5:0]       regn,
  output logic [DW-1:0]    addr
);
  import pcx_pkg::*;

  always_comb begin
    addr                 = '0;
    addr[ENABLE_BIT]     = 1'b1;
    addr[16 +: BUS_W]    = bus;
    addr[11 +: DEV_W]    = dev;
    addr[10:8]           = fn;
    addr[7:2]            = regn;
  end
endmodule

// File: rtl/pcicfg_xlate.sv
module pcicfg_xlate #(
  parameter int OFF_W = 16,
  parameter int DW    = 32,
  parameter int BUS_W = 8,
  parameter int TYPE1_BIT = 16,
  localparam int SEL_LO = 11,
  localparam int SEL_W  = DW - SEL_LO,
  localparam int DEV_W  = $clog2(SEL_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [1:0]       acc_size,
  input  logic [OFF_W-1:0] win_off,
  input  logic [DW-1:0]    map_reg,
  input  logic [BUS_W-1:0] bus_num,
  output logic [DW-1:0]    cfg_addr,
  output logic             fwd_valid,
  output logic [DW-1:0]    rej_rdata,
  output logic             clr_abort,
  output logic             err
);
  logic [DW-1:0]    raw;
  logic [DEV_W-1:0] dev_idx;
  logic             sel_empty;
  logic             accept;
  logic             fault;
  logic [DW-1:0]    fill;
  logic [DW-1:0]    addr_nxt;
  logic             fwd_nxt;
  logic             err_nxt;
  logic [DW-1:0]    rd_nxt;
  logic             addr_en;

  assign raw = {map_reg[DW-OFF_W-1:0], win_off};

  pcx_lsb_find #(.W(SEL_W)) u_find (
    .vec  (raw[DW-1:SEL_LO]),
    .idx  (dev_idx),
    .none (sel_empty)
  );

  pcx_screen #(.DW(DW)) u_screen (
    .size      (acc_size),
    .off_lo    (win_off[1:0]),
    .type1     (map_reg[TYPE1_BIT]),
    .sel_empty (sel_empty),
    .accept    (accept),
    .fault     (fault),
    .fill      (fill)
  );

  pcx_pack #(.BUS_W(BUS_W), .DEV_W(DEV_W), .DW(DW)) u_pack (
    .bus  (bus_num),
    .dev  (dev_idx),
    .fn   (raw[10:8]),
    .regn (raw[7:2]),
    .addr (addr_nxt)
  );

  always_comb begin
    fwd_nxt = acc_valid & accept;
    err_nxt = acc_valid & fault;
    rd_nxt  = (acc_valid & ~acc_write & ~accept) ? fill : '0;
    addr_en = fwd_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_valid <= 1'b0;
      clr_abort <= 1'b0;
      err       <= 1'b0;
      rej_rdata <= '0;
    end else begin
      fwd_valid <= fwd_nxt;
      clr_abort <= fwd_nxt;
      err       <= err_nxt;
      rej_rdata <= rd_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_addr <= '0;
    end else if (addr_en) begin
      cfg_addr <= addr_nxt;
    end
  end

  // R3
  fwd_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> (cfg_addr[DW-1] && cfg_addr[1:0] == 2'b00));

  // R6
  clr_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_abort == fwd_valid);

  // R7
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!fwd_valid && !clr_abort));

  // R9
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> (!fwd_valid && !err && rej_rdata == '0));

  // R5
  fill_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> (rej_rdata == '0));

  // R4
  type1_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && map_reg[TYPE1_BIT]) |=> (!fwd_valid && !err));

  // R6
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_abort && !acc_valid) |=> !clr_abort);
endmodule

// File: tb/pcicfg_xlate_bench.sv
module pcicfg_xlate_bench;
  logic        clk;
  logic        rst_n;
  logic        acc_valid;
  logic        acc_write;
  logic [1:0]  acc_size;
  logic [15:0] win_off;
  logic [31:0] map_reg;
  logic [7:0]  bus_num;
  logic [31:0] cfg_addr;
  logic        fwd_valid;
  logic [31:0] rej_rdata;
  logic        clr_abort;
  logic        err;

  typedef struct packed {
    logic [31:0] addr;
    logic        fv;
    logic [31:0] rd;
    logic        clr;
    logic        er;
    logic [7:0]  tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  pcicfg_xlate u_pcicfg_xlate (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_size(acc_size), .win_off(win_off), .map_reg(map_reg), .bus_num(bus_num),
    .cfg_addr(cfg_addr), .fwd_valid(fwd_valid), .rej_rdata(rej_rdata),
    .clr_abort(clr_abort), .err(err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic exp_t model(input logic v, input logic wr, input logic [1:0] sz,
                                 input logic [15:0] off, input logic [31:0] mp,
                                 input logic [7:0] bus, input logic [7:0] tag);
    exp_t e;
    logic [31:0] raw;
    logic [20:0] sel;
    logic        mis, t1, acc;
    int          dev;
    raw = {mp[15:0], off};
    sel = raw[31:11];
    t1  = mp[16];
    mis = (sz == 2'd1) ? off[0] : (sz >= 2'd2) ? (off[1:0] != 2'b00) : 1'b0;
    dev = 0;
    for (int k = 20; k >= 0; k--) if (sel[k]) dev = k;
    acc = v && !t1 && !mis && (sel != 0);
    e.fv   = acc;
    e.clr  = acc;
    e.er   = v && !t1 && (mis || sel == 0);
    e.rd   = (v && !wr && !acc) ? ((sz == 2'd0) ? 32'h0000_00FF :
                                   (sz == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF) : 32'h0;
    e.addr = 32'h8000_0000 | ({24'h0, bus} << 16) | (dev << 11) | (raw & 32'h0000_07FC);
    e.tag  = tag;
    return e;
  endfunction

  task automatic drive(input logic v, input logic wr, input logic [1:0] sz,
                       input logic [15:0] off, input logic [31:0] mp,
                       input logic [7:0] bus, input logic [7:0] tag);
    @(negedge clk);
    acc_valid = v; acc_write = wr; acc_size = sz;
    win_off = off; map_reg = mp; bus_num = bus;
    exp_q.push_back(model(v, wr, sz, off, mp, bus, tag));
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) drive(1'b0, 1'b0, 2'd0, 16'h0, 32'h0, 8'h0, 8'd9);
  endtask

  // monitor: compares each result 2 ns after the edge that registered it
  always @(posedge clk) begin
    #2;
    if (rst_n && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (fwd_valid !== e.fv || clr_abort !== e.clr || err !== e.er ||
          rej_rdata !== e.rd || (e.fv && cfg_addr !== e.addr)) begin
        fails++;
        $display("FAIL R%0d: fv=%b clr=%b err=%b rd=%h addr=%h, expected fv=%b clr=%b err=%b rd=%h addr=%h",
                 e.tag, fwd_valid, clr_abort, err, rej_rdata, cfg_addr,
                 e.fv, e.clr, e.er, e.rd, e.addr);
      end
    end
  end

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    acc_valid = 1'b0; acc_write = 1'b0; acc_size = 2'd0;
    win_off = 16'h0; map_reg = 32'h0; bus_num = 8'h0;
    repeat (3) @(negedge clk);
    // R10 reset state
    checks++;
    if (fwd_valid !== 1'b0 || clr_abort !== 1'b0 || err !== 1'b0 ||
        rej_rdata !== 32'h0 || cfg_addr !== 32'h0) begin
      fails++;
      $display("FAIL R10: fv=%b clr=%b err=%b rd=%h addr=%h, expected all zero",
               fwd_valid, clr_abort, err, rej_rdata, cfg_addr);
    end
    rst_n = 1'b1;
    // R1 R3 word read, select bit at raw bit 11, function and register fields
    drive(1, 0, 2'd2, 16'h0A5C, 32'h0000_0000, 8'h3C, 8'd1);
    // R2 select at raw bit 15 -> device 4, halfword write
    drive(1, 1, 2'd1, 16'h8102, 32'h0000_0000, 8'h01, 8'd2);
    // R2 select at map bit 0 -> device 5
    drive(1, 0, 2'd0, 16'h0033, 32'h0000_0001, 8'hFF, 8'd2);
    // R2 select at map bit 15 -> device 20
    drive(1, 0, 2'd2, 16'h00F8, 32'h0000_8000, 8'h7E, 8'd2);
    // R2 multiple bits set, lowest wins (raw bit 13 -> device 2)
    drive(1, 1, 2'd2, 16'hE004, 32'h0000_00F0, 8'h11, 8'd2);
    // R9 idle gap
    idle(2);
    // R4 type-1 read at every width
    drive(1, 0, 2'd0, 16'h0800, 32'h0001_0000, 8'h00, 8'd4);
    drive(1, 0, 2'd1, 16'h0800, 32'h0001_0000, 8'h00, 8'd4);
    drive(1, 0, 2'd2, 16'h0800, 32'h0001_0000, 8'h00, 8'd4);
    drive(1, 0, 2'd3, 16'h0801, 32'h0001_0020, 8'h00, 8'd4);
    // R5 type-1 write dropped
    drive(1, 1, 2'd2, 16'h0800, 32'h0001_0000, 8'h00, 8'd5);
    // R7 misaligned halfword and word, byte at odd offset accepted
    drive(1, 0, 2'd1, 16'h0801, 32'h0000_0000, 8'h02, 8'd7);
    drive(1, 1, 2'd2, 16'h0802, 32'h0000_0000, 8'h02, 8'd7);
    drive(1, 0, 2'd3, 16'h0803, 32'h0000_0000, 8'h02, 8'd7);
    drive(1, 0, 2'd0, 16'h0803, 32'h0000_0000, 8'h02, 8'd7);
    // R8 empty select: read gets fill, write nothing, then normal again
    drive(1, 0, 2'd1, 16'h0004, 32'h0000_0000, 8'h05, 8'd8);
    drive(1, 1, 2'd2, 16'h0000, 32'h0000_0000, 8'h05, 8'd8);
    drive(1, 0, 2'd2, 16'h1000, 32'h0000_0000, 8'h05, 8'd8);
    // R6 back-to-back accepted accesses keep pulse per access
    drive(1, 1, 2'd2, 16'h4010, 32'h0000_0000, 8'h09, 8'd6);
    drive(1, 0, 2'd2, 16'h4014, 32'h0000_0000, 8'h09, 8'd6);
    idle(1);
    // R9 mixed random traffic
    for (int n = 0; n < 400; n++) begin
      logic [31:0] mp;
      logic [15:0] off;
      mp  = $urandom() & 32'h0001_FFFF;
      off = $urandom();
      if (($urandom() % 4) == 0) begin
        mp  = mp & 32'h0001_0000;
        off = off & 16'h07FF;
      end
      drive(($urandom() % 3) != 0, $urandom() % 2, 2'($urandom() % 4),
            off, mp, 8'($urandom()), 8'd9);
    end
    idle(2);
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule